// File: doc/BRIEF.md
# Coincidence-Gated Reciprocal Pulse Counter

This block sits in a high-frequency quantising clock domain and turns a train of phase-coincidence pulses into a measurement gate that spans a whole group period of two signals. Every coincidence pulse is measured by counting the quantising-clock cycles it stays high. After the block is armed, it skips to a chosen coincidence event. It stores the width of that event and opens the gate. While the gate is open it counts rising edges of the reference narrow pulses and of the measured narrow pulses side by side. The gate closes on a later coincidence event whose quantised width equals the stored one. Because both counters start and stop on the same two events, their ratio spans whole periods of both signals. A miscount of one cycle on a width only pushes closure to a later repeat of the group period, so the ratio stays valid.

Both counts and the stored width leave the block on a valid/ready result port. The result stays valid, with the data unchanged, until the consumer asserts ready. Ready has no effect while valid and error are both low. A gate that stays open too long without a matching width is abandoned. In that case the error flag rises in place of valid and is cleared by the same ready handshake. A new measurement starts only when the block is re-armed from idle.

Top module: `coin_gate_counter`

## Requirements
- R1: After reset, `gate_o`, `res_valid_o` and `res_err_o` are low and both count outputs are zero.
- R2: A coincidence event is the cycle in which `coin_i`, high in the previous sample, is sampled low. The event's width is the number of consecutive samples in which `coin_i` was high, saturating at the largest value `res_width_o` can hold. `res_width_o` reports the width of the opening event.
- R3: After arming, the gate opens on the Nth coincidence event, where N is `sel_n_i`. A value of 0 is treated as 1.
- R4: The gate closes on the first later event whose width equals the stored width and that is at least the M-th event after the opening one, where M is `min_ev_i`. A value of 0 is treated as 1. Events of a different width do not close it.
- R5: Take k as the sample index of the opening event and m as the sample index of the closing event. A pulse rising edge sampled at index j is counted exactly when k+2 <= j <= m+1. `gate_o` is high for the cycles in that window.
- R6: The reference and measured inputs are counted over the same window. Each counts rising edges only, so a pulse held high over several cycles counts once.
- R7: After a close, `res_valid_o` rises with the counts and the width. These stay stable until a cycle with `res_ready_i` high. The cycle after that, `res_valid_o` is low.
- R8: If no closing event occurs at an index m <= k+T+1, where T is `timeout_i`, the gate is abandoned. `res_err_o` rises and `res_valid_o` does not. At most T+1 gate cycles elapse, and the error flag is held until `res_ready_i`. `res_valid_o` and `res_err_o` are never high together.
- R9: `arm_i` is ignored unless the block is idle. After a result is handed off, no gate opens until `arm_i` is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quantising clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a measurement (idle only) |
| sel_n_i | input | SEL_W | Index of the opening event after arming |
| min_ev_i | input | MINEV_W | Minimum events from opening to closing |
| timeout_i | input | TMO_W | Gate cycle limit before abort |
| coin_i | input | 1 | Coincidence pulse |
| ref_pulse_i | input | 1 | Reference narrow pulses |
| meas_pulse_i | input | 1 | Measured narrow pulses |
| gate_o | output | 1 | Gate open |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted / error acknowledged |
| res_err_o | output | 1 | Gate abandoned on timeout |
| res_ref_cnt_o | output | CNT_W | Reference rising edges in the gate |
| res_meas_cnt_o | output | CNT_W | Measured rising edges in the gate |
| res_width_o | output | WIDTH_W | Stored coincidence width |

## Verification
A corrupted stored width or event tally shows up as a result that arrives too early or never arrives. The timeout then raises the error flag within T+2 cycles of opening. An error in the pulse-edge register or in the gate enable shifts a count by one or more. That difference is visible at the result handshake that ends the same measurement. A broken hold path shows up in the first stalled cycle of the handshake as data or valid changing while ready is low.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_OPEN,
    ST_DONE,
    ST_FAIL
  } cgc_state_e;
endpackage

// File: rtl/cgc_width_meter.sv
// Quantises each high stretch of a level and emits a registered event with its width.
module cgc_width_meter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lvl_i,
  output logic         ev_o,
  output logic [W-1:0] width_o
);
  localparam logic [W-1:0] MAX_W = {W{1'b1}};
  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  logic         lvl_q;
  logic [W-1:0] run_q;
  logic         fall;

  assign fall = lvl_q & ~lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      run_q   <= '0;
      ev_o    <= 1'b0;
      width_o <= '0;
    end else begin
      lvl_q <= lvl_i;
      ev_o  <= fall;
      if (fall) width_o <= run_q;
      if (lvl_i) begin
        if (!lvl_q)            run_q <= ONE_W;
        else if (run_q != MAX_W) run_q <= run_q + ONE_W;
      end
    end
  end
endmodule

// File: rtl/cgc_pulse_acc.sv
// Counts rising edges of a pulse input while enabled; synchronous clear.
module cgc_pulse_acc #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          pulse_i,
  output logic [CW-1:0] cnt_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cnt_o   <= '0;
    end else begin
      pulse_q <= pulse_i;
      if (clr_i)                          cnt_o <= '0;
      else if (en_i && pulse_i && !pulse_q) cnt_o <= cnt_o + {{(CW-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/cgc_gate_ctrl.sv
// Arming, opening-event selection, width match closing and timeout.
module cgc_gate_ctrl
  import cgc_pkg::*;
#(
  parameter int WIDTH_W = 8,
  parameter int SEL_W   = 4,
  parameter int MINEV_W = 4,
  parameter int TMO_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [SEL_W-1:0]   sel_n_i,
  input  logic [MINEV_W-1:0] min_ev_i,
  input  logic [TMO_W-1:0]   timeout_i,
  input  logic               ev_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               ready_i,
  output logic               clr_o,
  output logic               gate_o,
  output logic               valid_o,
  output logic               err_o,
  output logic [WIDTH_W-1:0] width_hold_o
);
  localparam logic [SEL_W:0]   ONE_S = {{SEL_W{1'b0}}, 1'b1};
  localparam logic [MINEV_W:0] ONE_M = {{MINEV_W{1'b0}}, 1'b1};
  localparam logic [MINEV_W-1:0] GMAX = {MINEV_W{1'b1}};

  cgc_state_e         state_q;
  logic [SEL_W-1:0]   seen_q;
  logic [MINEV_W-1:0] gcnt_q;
  logic [TMO_W-1:0]   tcnt_q;

  logic [SEL_W:0]   seen_nx, eff_n;
  logic [MINEV_W:0] gcnt_nx, eff_min;
  logic             match;

  always_comb begin
    seen_nx = {1'b0, seen_q} + ONE_S;
    eff_n   = (sel_n_i == '0) ? ONE_S : {1'b0, sel_n_i};
    gcnt_nx = {1'b0, gcnt_q} + ONE_M;
    eff_min = (min_ev_i == '0) ? ONE_M : {1'b0, min_ev_i};
    match   = ev_i && (width_i == width_hold_o) && (gcnt_nx >= eff_min);
  end

  assign clr_o   = (state_q == ST_IDLE) && arm_i;
  assign gate_o  = (state_q == ST_OPEN);
  assign valid_o = (state_q == ST_DONE);
  assign err_o   = (state_q == ST_FAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      seen_q       <= '0;
      gcnt_q       <= '0;
      tcnt_q       <= '0;
      width_hold_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          state_q <= ST_SEEK;
          seen_q  <= '0;
        end
        ST_SEEK: if (ev_i) begin
          if (seen_nx >= eff_n) begin
            state_q      <= ST_OPEN;
            width_hold_o <= width_i;
            gcnt_q       <= '0;
            tcnt_q       <= '0;
          end else begin
            seen_q <= seen_nx[SEL_W-1:0];
          end
        end
        ST_OPEN: begin
          if (match)                    state_q <= ST_DONE;
          else if (tcnt_q >= timeout_i) state_q <= ST_FAIL;
          else begin
            tcnt_q <= tcnt_q + {{(TMO_W-1){1'b0}}, 1'b1};
            if (ev_i && gcnt_q != GMAX) gcnt_q <= gcnt_nx[MINEV_W-1:0];
          end
        end
        ST_DONE, ST_FAIL: if (ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coin_gate_counter.sv
module coin_gate_counter #(
  parameter int WIDTH_W = 8,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4,
  parameter int MINEV_W = 4,
  parameter int TMO_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [SEL_W-1:0]   sel_n_i,
  input  logic [MINEV_W-1:0] min_ev_i,
  input  logic [TMO_W-1:0]   timeout_i,
  input  logic               coin_i,
  input  logic               ref_pulse_i,
  input  logic               meas_pulse_i,
  output logic               gate_o,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic               res_err_o,
  output logic [CNT_W-1:0]   res_ref_cnt_o,
  output logic [CNT_W-1:0]   res_meas_cnt_o,
  output logic [WIDTH_W-1:0] res_width_o
);
  localparam int NCH = 2;

  logic               ev;
  logic [WIDTH_W-1:0] ev_width;
  logic               clr;
  logic [NCH-1:0]     pulse_vec;
  logic [CNT_W-1:0]   cnt_arr [NCH];

  assign pulse_vec = {meas_pulse_i, ref_pulse_i};

  cgc_width_meter #(.W(WIDTH_W)) u_width (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (coin_i),
    .ev_o    (ev),
    .width_o (ev_width)
  );

  cgc_gate_ctrl #(
    .WIDTH_W(WIDTH_W), .SEL_W(SEL_W), .MINEV_W(MINEV_W), .TMO_W(TMO_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .sel_n_i      (sel_n_i),
    .min_ev_i     (min_ev_i),
    .timeout_i    (timeout_i),
    .ev_i         (ev),
    .width_i      (ev_width),
    .ready_i      (res_ready_i),
    .clr_o        (clr),
    .gate_o       (gate_o),
    .valid_o      (res_valid_o),
    .err_o        (res_err_o),
    .width_hold_o (res_width_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    cgc_pulse_acc #(.CW(CNT_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .en_i    (gate_o),
      .pulse_i (pulse_vec[ch]),
      .cnt_o   (cnt_arr[ch])
    );
  end

  assign res_ref_cnt_o  = cnt_arr[0];
  assign res_meas_cnt_o = cnt_arr[1];
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
  parameter int WIDTH_W = 8,
  parameter int CNT_W   = 32,
  parameter int TMO_W   = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arm_i,
  input logic [TMO_W-1:0]   timeout_i,
  input logic               gate_o,
  input logic               res_valid_o,
  input logic               res_ready_i,
  input logic               res_err_o,
  input logic [CNT_W-1:0]   res_ref_cnt_o,
  input logic [CNT_W-1:0]   res_meas_cnt_o,
  input logic [WIDTH_W-1:0] res_width_o
);
  localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};
  logic [TMO_W:0] open_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_run <= '0;
    else if (gate_o) open_run <= open_run + {{TMO_W{1'b0}}, 1'b1};
    else             open_run <= '0;
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_ref_cnt_o)
      && $stable(res_meas_cnt_o) && $stable(res_width_o)));

  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && res_err_o));

  a_r8_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (open_run <= {1'b0, timeout_i}));

  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_o && !arm_i) |=> ($stable(res_ref_cnt_o) && $stable(res_meas_cnt_o)));

  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |=> ((res_ref_cnt_o - $past(res_ref_cnt_o)) <= ONE_C
      && (res_meas_cnt_o - $past(res_meas_cnt_o)) <= ONE_C));

  a_r4_close_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> (res_valid_o || res_err_o));

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || res_err_o) |=> !gate_o);
endmodule

bind coin_gate_counter cgc_checker #(
  .WIDTH_W(WIDTH_W), .CNT_W(CNT_W), .TMO_W(TMO_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .arm_i          (arm_i),
  .timeout_i      (timeout_i),
  .gate_o         (gate_o),
  .res_valid_o    (res_valid_o),
  .res_ready_i    (res_ready_i),
  .res_err_o      (res_err_o),
  .res_ref_cnt_o  (res_ref_cnt_o),
  .res_meas_cnt_o (res_meas_cnt_o),
  .res_width_o    (res_width_o)
);

// File: tb/coin_gate_counter_tb_top.sv
module coin_gate_counter_tb_top;
  localparam int LMAX = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, coin = 1'b0, refp = 1'b0, measp = 1'b0, ready = 1'b0;
  logic [3:0]  sel_n = 4'd3, min_ev = 4'd1;
  logic [23:0] tmo = 24'd100000;
  logic        gate, valid, err;
  logic [31:0] ref_cnt, meas_cnt;
  logic [7:0]  width;

  int errors = 0, checks = 0;
  bit c_a [LMAX];
  bit r_a [LMAX];
  bit m_a [LMAX];
  int len;
  int exp_ref, exp_meas, exp_w;
  bit exp_err, exp_ok;

  always #5 clk = ~clk;

  coin_gate_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sel_n_i(sel_n), .min_ev_i(min_ev),
    .timeout_i(tmo), .coin_i(coin), .ref_pulse_i(refp), .meas_pulse_i(measp),
    .gate_o(gate), .res_valid_o(valid), .res_ready_i(ready), .res_err_o(err),
    .res_ref_cnt_o(ref_cnt), .res_meas_cnt_o(meas_cnt), .res_width_o(width)
  );

  task automatic chk(input bit ok, input string tag, input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  // Random train: gaps, coincidence widths 1..4, random reference/measured levels.
  task automatic gen_random(input int nev);
    int p = 0;
    for (int e = 0; e < nev; e++) begin
      int gap = 3 + int'($urandom % 6);
      int w = 1 + int'($urandom % 4);
      for (int i = 0; i < gap + w; i++) begin
        c_a[p] = (i >= gap);
        r_a[p] = ($urandom % 3) == 0;
        m_a[p] = ($urandom % 5) == 0;
        p++;
      end
    end
    for (int i = 0; i < 12; i++) begin
      c_a[p] = 0; r_a[p] = 0; m_a[p] = 0; p++;
    end
    len = p;
  endtask

  // Directed train: strictly growing widths, so no width ever repeats.
  task automatic gen_distinct();
    int p = 0;
    for (int e = 0; e < 8; e++) begin
      for (int i = 0; i < 9 + e + 1; i++) begin
        c_a[p] = (i >= 9);
        r_a[p] = (i % 2) == 0;
        m_a[p] = (i % 3) == 0;
        p++;
      end
    end
    for (int i = 0; i < 12; i++) begin
      c_a[p] = 0; r_a[p] = 0; m_a[p] = 0; p++;
    end
    len = p;
  endtask

  // Expected result from the requirement rules (R2..R6, R8).
  task automatic compute_expected(input int n, input int mn, input int t);
    int run = 0, falls = 0, k = -1, m = -1, g = 0;
    bit prev = 0;
    int effn = (n == 0) ? 1 : n;
    int effm = (mn == 0) ? 1 : mn;
    exp_ok = 1; exp_err = 0; exp_ref = 0; exp_meas = 0; exp_w = 0;
    for (int j = 0; j < len; j++) begin
      if (c_a[j]) run++;
      else if (prev) begin
        if (run > 255) run = 255;
        if (k < 0) begin
          falls++;
          if (falls >= effn) begin k = j; exp_w = run; end
        end else if (m < 0) begin
          g++;
          if (run == exp_w && g >= effm) m = j;
        end
        run = 0;
      end
      prev = c_a[j];
    end
    if (k < 0) begin exp_ok = 0; return; end
    if (m < 0 || m - k > t + 1) begin
      exp_err = 1;
      if (k + t + 4 >= len) exp_ok = 0;
      return;
    end
    for (int j = k + 2; j <= m + 1 && j < len; j++) begin
      if (r_a[j] && (j == 0 || !r_a[j-1])) exp_ref++;
      if (m_a[j] && (j == 0 || !m_a[j-1])) exp_meas++;
    end
  endtask

  task automatic play(input int arm_at, output int gate_seen);
    gate_seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gate) gate_seen++;
      coin = c_a[i]; refp = r_a[i]; measp = m_a[i]; arm = (i == arm_at);
    end
    @(negedge clk);
    coin = 0; refp = 0; measp = 0; arm = 0;
  endtask

  task automatic run_case(input int n, input int mn, input int t, input int arm_at);
    int gs;
    logic [31:0] h_ref, h_meas;
    logic [7:0] h_w;
    sel_n = 4'(n); min_ev = 4'(mn); tmo = 24'(t);
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    repeat (2) @(negedge clk);
    play(arm_at, gs);
    @(negedge clk);
    if (exp_err) begin
      chk(err == 1'b1, "R8 error flag", err, 1);
      chk(valid == 1'b0, "R8 no valid on timeout", valid, 0);
    end else begin
      chk(valid == 1'b1, "R4 closed with valid", valid, 1);
      chk(ref_cnt == 32'(exp_ref), "R5 reference count", ref_cnt, exp_ref);
      chk(meas_cnt == 32'(exp_meas), "R6 measured count", meas_cnt, exp_meas);
      chk(width == 8'(exp_w), "R2 stored width", width, exp_w);
    end
    h_ref = ref_cnt; h_meas = meas_cnt; h_w = width;
    arm = 1;
    repeat (3) @(negedge clk);
    arm = 0;
    chk((valid == !exp_err) && (err == exp_err) && ref_cnt == h_ref && meas_cnt == h_meas
        && width == h_w, "R7/R9 hold while stalled, arm ignored", ref_cnt, h_ref);
    ready = 1;
    @(negedge clk); ready = 0;
    chk(!valid && !err, "R7 flags drop after ready", {valid, err}, 0);
  endtask

  initial begin
    int gs;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!gate && !valid && !err && ref_cnt == 0 && meas_cnt == 0, "R1 reset state",
        {gate, valid, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!gate && !valid && !err && ref_cnt == 0 && meas_cnt == 0, "R1 state after release",
        ref_cnt, 0);

    // Directed: default selection, no repeat, short timeout (R8).
    gen_distinct();
    compute_expected(1, 1, 20);
    run_case(1, 1, 20, -1);

    // Directed: sel 0 means 1, min 0 means 1 (R3, R4).
    for (int tries = 0; tries < 50; tries++) begin
      gen_random(30);
      compute_expected(0, 0, 100000);
      if (exp_ok && !exp_err) break;
    end
    run_case(0, 0, 100000, -1);

    // Random mix: N, M, timeout, a stray arm during the gate (R3..R9).
    for (int c = 0; c < 8; c++) begin
      int n, mn, t, aa;
      do begin
        n = int'($urandom % 5);
        mn = int'($urandom % 4);
        t = (($urandom % 3) == 0) ? 30 : 100000;
        gen_random(40);
        compute_expected(n, mn, t);
      end while (!exp_ok);
      aa = 40 + int'($urandom % 100);
      run_case(n, mn, t, aa);
    end

    // R9: without re-arm no gate opens and no result appears.
    gen_random(20);
    play(-1, gs);
    repeat (3) @(negedge clk);
    chk(gs == 0 && !gate && !valid, "R9 no gate without re-arm", gs, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule